// File: doc/BRIEF.md
# Posted CAS Latency Scheduler

This block models the command-side timing of a double-data-rate memory device whose column commands may be posted early. A controller drives one command per clock on a small opcode bus. Two of the opcodes load configuration: one loads the CAS latency and the other loads the additive latency. ACTIVATE opens a row in a bank. READ and WRITE carry a bank and a column.

Each accepted READ or WRITE waits in a shift pipeline for exactly the additive latency. It then appears on an internal issue port with its bank and column. The block derives a read-data window and a write-capture window from the sum of the two latencies. Because the issue is delayed, a controller may send a column command before the row-to-column delay has elapsed. The block tracks the time since ACTIVATE for every bank and flags any column command that is still too early once the additive latency is counted in.

A configuration write is refused in two cases: when it carries a reserved code, and when it arrives while commands are still in the pipeline. Each case raises its own one-cycle flag.

Top module: `posted_cas_sched`

## Requirements
- R1: After reset, `al_now` reads 0 and `cl_now` reads 3. The windows, the issue strobe and all three flags are low.
- R2: Opcode 5 programs the additive latency from `cmd_addr[5:3]`. Codes 0 to 4 are legal, provided the code does not exceed `TRCD_MIN`. The new value appears on `al_now` in the cycle after the command edge.
- R3: Opcode 4 programs the CAS latency from `cmd_addr[6:4]`. Codes 3 to 6 are legal. The new value appears on `cl_now` in the cycle after the command edge.
- R4: A configuration opcode carrying a reserved code leaves both latencies unchanged. It raises `cfg_illegal` for the one cycle after the command edge.
- R5: A READ (opcode 2) or WRITE (opcode 3) sampled at edge k drives `iss_valid` for the one cycle after edge k+AL. In that cycle `iss_write`, `iss_bank` and `iss_col` carry the command's values.
- R6: For a READ sampled at edge k, `rd_window` is high for the two cycles after edges k+RL and k+RL+1, where RL = AL+CL. It is low otherwise.
- R7: For a WRITE, `wr_window` covers the same two-cycle span at WL = RL-1.
- R8: Column commands spaced two clocks apart all issue, in order, with no loss. Their read windows join into one unbroken run.
- R9: Let g be the number of clocks from ACTIVATE (opcode 1) to a column command on the same bank. If g + AL < `TRCD_MIN`, `rcd_early` is high for the cycle after the column command's edge. A bank that has never been activated never flags.
- R10: A configuration opcode that arrives while any command is still before the end of its data window is ignored. It raises `cfg_busy` for one cycle and does not disturb the commands already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Opcode: 0 idle, 1 activate, 2 read, 3 write, 4 CAS-latency load, 5 additive-latency load |
| cmd_bank | input | BANK_W | Bank of the command |
| cmd_addr | input | ADDR_W | Column, or the configuration value |
| iss_valid | output | 1 | Internal issue strobe |
| iss_write | output | 1 | Issued command is a write |
| iss_bank | output | BANK_W | Issued bank |
| iss_col | output | ADDR_W | Issued column |
| rd_window | output | 1 | Read data valid window |
| wr_window | output | 1 | Write data capture window |
| al_now | output | 3 | Current additive latency |
| cl_now | output | 3 | Current CAS latency |
| cfg_illegal | output | 1 | Reserved configuration code refused |
| cfg_busy | output | 1 | Configuration refused while busy |
| rcd_early | output | 1 | Column command too early after activate |

## Verification
A stage of the pipeline that is dropped or duplicated shows up as a missing or extra issue strobe exactly AL cycles after the command. It also moves a data window off its RL or WL position, and at two-clock spacing it breaks the joined window run. A latency register that takes a refused value shows on `al_now` or `cl_now` one cycle later, and every later window then lands at the wrong cycle. A per-bank counter that does not restart or does not saturate shows up on `rcd_early` one cycle after the offending column command.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_ACT  = 3'd1,
      OP_RD   = 3'd2,
      OP_WR   = 3'd3,
      OP_CLSET = 3'd4,
      OP_ALSET = 3'd5
   } pcs_op_e;

   localparam int FIELD_W = 3;
   localparam int AL_LSB  = 3;   // additive latency field position
   localparam int CL_LSB  = 4;   // CAS latency field position
endpackage

// File: rtl/pcs_mode_regs.sv
module pcs_mode_regs
   import pcs_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int AL_MAX   = 4,
   parameter int CL_MIN   = 3,
   parameter int CL_MAX   = 6,
   parameter int TRCD_MIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy,
   output logic [2:0]        al_q,
   output logic [2:0]        cl_q,
   output logic              illegal_q,
   output logic              busy_q
);
   localparam int AL_CAP_I = (AL_MAX < TRCD_MIN) ? AL_MAX : TRCD_MIN;
   localparam logic [2:0] AL_LIM = 3'(AL_CAP_I);
   localparam logic [2:0] CL_LO  = 3'(CL_MIN);
   localparam logic [2:0] CL_HI  = 3'(CL_MAX);

   logic       is_al, is_cl, is_cfg, legal;
   logic [2:0] code;

   always_comb begin
      is_al  = (op == OP_ALSET);
      is_cl  = (op == OP_CLSET);
      is_cfg = is_al | is_cl;
      code   = is_al ? addr[AL_LSB +: FIELD_W] : addr[CL_LSB +: FIELD_W];
      legal  = is_al ? (code <= AL_LIM) : ((code >= CL_LO) && (code <= CL_HI));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         al_q      <= 3'd0;
         cl_q      <= CL_LO;
         illegal_q <= 1'b0;
         busy_q    <= 1'b0;
      end else begin
         illegal_q <= is_cfg & ~legal;
         busy_q    <= is_cfg & busy;
         if (is_cfg && legal && !busy) begin
            if (is_al) al_q <= code;
            else       cl_q <= code;
         end
      end
   end

   a_r2_al_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      al_q <= AL_LIM);
   a_r3_cl_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cl_q >= CL_LO) && (cl_q <= CL_HI));
   a_r4_illegal_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cfg && !legal) |=> ($stable(al_q) && $stable(cl_q)));
   a_r10_busy_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cfg && busy) |=> ($stable(al_q) && $stable(cl_q)));
endmodule

// File: rtl/pcs_defer_pipe.sv
module pcs_defer_pipe #(
   parameter int BANK_W = 2,
   parameter int ADDR_W = 13,
   parameter int DEPTH  = 12,
   parameter int WIN    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              push_wr,
   input  logic [BANK_W-1:0] push_bank,
   input  logic [ADDR_W-1:0] push_col,
   input  logic [2:0]        al,
   input  logic [2:0]        cl,
   output logic              iss_valid,
   output logic              iss_wr,
   output logic [BANK_W-1:0] iss_bank,
   output logic [ADDR_W-1:0] iss_col,
   output logic              rd_win,
   output logic              wr_win,
   output logic              busy
);
   logic [DEPTH-1:0]  v_q, w_q;
   logic [BANK_W-1:0] bk_q  [DEPTH];
   logic [ADDR_W-1:0] col_q [DEPTH];
   logic [4:0]        rl, wl, span;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         w_q <= '0;
      end else begin
         v_q <= {v_q[DEPTH-2:0], push};
         w_q <= {w_q[DEPTH-2:0], push_wr & push};
      end
   end

   always_ff @(posedge clk) begin
      for (int s = DEPTH - 1; s > 0; s--) begin
         bk_q[s]  <= bk_q[s-1];
         col_q[s] <= col_q[s-1];
      end
      bk_q[0]  <= push_bank;
      col_q[0] <= push_col;
   end

   always_comb begin
      rl        = 5'(al) + 5'(cl);
      wl        = rl - 5'd1;
      span      = rl + 5'(WIN);
      iss_valid = 1'b0;
      iss_wr    = 1'b0;
      iss_bank  = '0;
      iss_col   = '0;
      rd_win    = 1'b0;
      wr_win    = 1'b0;
      busy      = 1'b0;
      for (int s = 0; s < DEPTH; s++) begin
         if (5'(s) == 5'(al)) begin
            iss_valid = v_q[s];
            iss_wr    = w_q[s];
            iss_bank  = bk_q[s];
            iss_col   = col_q[s];
         end
         if (v_q[s] && !w_q[s] && (5'(s) >= rl) && (5'(s) < span))
            rd_win = 1'b1;
         if (v_q[s] && w_q[s] && (5'(s) >= wl) && (5'(s) < wl + 5'(WIN)))
            wr_win = 1'b1;
         if (v_q[s] && (5'(s) < span))
            busy = 1'b1;
      end
   end

   a_r5_al0_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (push && al == 3'd0) |=> iss_valid);

   generate
      if (WIN > 1) begin : g_win_chk
         a_r6_rd_window_pair: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_win) |=> rd_win);
      end
   endgenerate
endmodule

// File: rtl/pcs_act_timer.sv
module pcs_act_timer #(
   parameter int BANKS    = 4,
   parameter int BANK_W   = 2,
   parameter int TRCD_MIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic              col_cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [2:0]        al,
   output logic              early_q
);
   localparam int CNT_W = $clog2(TRCD_MIN + 1);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(TRCD_MIN);

   logic [CNT_W-1:0] cnt_all [BANKS];
   logic [CNT_W-1:0] sel;
   logic [5:0]       reach;

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt_q <= CAP;
            else if (act && bank == BANK_W'(b))  cnt_q <= CNT_W'(1);
            else if (cnt_q != CAP)               cnt_q <= cnt_q + 1'b1;
         end
         assign cnt_all[b] = cnt_q;
      end
   endgenerate

   always_comb begin
      sel   = cnt_all[bank];
      reach = 6'(sel) + 6'(al);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) early_q <= 1'b0;
      else        early_q <= col_cmd && (reach < 6'(TRCD_MIN));
   end

   a_r9_settled_bank_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (col_cmd && sel == CAP) |=> !early_q);
endmodule

// File: rtl/posted_cas_sched.sv
module posted_cas_sched
   import pcs_pkg::*;
#(
   parameter int BANKS     = 4,
   parameter int ADDR_W    = 13,
   parameter int AL_MAX    = 4,
   parameter int CL_MIN    = 3,
   parameter int CL_MAX    = 6,
   parameter int TRCD_MIN  = 4,
   parameter int BURST_LEN = 4,
   localparam int BANK_W   = $clog2(BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_op,
   input  logic [BANK_W-1:0] cmd_bank,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic              iss_valid,
   output logic              iss_write,
   output logic [BANK_W-1:0] iss_bank,
   output logic [ADDR_W-1:0] iss_col,
   output logic              rd_window,
   output logic              wr_window,
   output logic [2:0]        al_now,
   output logic [2:0]        cl_now,
   output logic              cfg_illegal,
   output logic              cfg_busy,
   output logic              rcd_early
);
   localparam int WIN   = BURST_LEN / 2;
   localparam int DEPTH = AL_MAX + CL_MAX + WIN;

   generate
      if (BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
         $error("BURST_LEN must be 4 or 8");
      end
      if (AL_MAX > 7 || CL_MAX > 7 || CL_MIN < 1 || CL_MIN > CL_MAX) begin : g_bad_lat
         $error("latency limits out of range");
      end
      if (TRCD_MIN < 2 || TRCD_MIN > 31) begin : g_bad_rcd
         $error("TRCD_MIN out of range");
      end
      if ((1 << BANK_W) != BANKS) begin : g_bad_banks
         $error("BANKS must be a power of two");
      end
      if (ADDR_W < 7 || DEPTH > 31) begin : g_bad_width
         $error("address too narrow or pipeline too deep");
      end
   endgenerate

   logic is_col, is_wr, is_act, pipe_busy;

   always_comb begin
      is_wr  = (cmd_op == OP_WR);
      is_col = (cmd_op == OP_RD) | is_wr;
      is_act = (cmd_op == OP_ACT);
   end

   pcs_mode_regs #(
      .ADDR_W(ADDR_W), .AL_MAX(AL_MAX), .CL_MIN(CL_MIN),
      .CL_MAX(CL_MAX), .TRCD_MIN(TRCD_MIN)
   ) u_mode (
      .clk(clk), .rst_n(rst_n), .op(cmd_op), .addr(cmd_addr), .busy(pipe_busy),
      .al_q(al_now), .cl_q(cl_now), .illegal_q(cfg_illegal), .busy_q(cfg_busy)
   );

   pcs_defer_pipe #(
      .BANK_W(BANK_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WIN(WIN)
   ) u_pipe (
      .clk(clk), .rst_n(rst_n), .push(is_col), .push_wr(is_wr),
      .push_bank(cmd_bank), .push_col(cmd_addr), .al(al_now), .cl(cl_now),
      .iss_valid(iss_valid), .iss_wr(iss_write), .iss_bank(iss_bank),
      .iss_col(iss_col), .rd_win(rd_window), .wr_win(wr_window), .busy(pipe_busy)
   );

   pcs_act_timer #(
      .BANKS(BANKS), .BANK_W(BANK_W), .TRCD_MIN(TRCD_MIN)
   ) u_rcd (
      .clk(clk), .rst_n(rst_n), .act(is_act), .col_cmd(is_col),
      .bank(cmd_bank), .al(al_now), .early_q(rcd_early)
   );
endmodule

// File: tb/sim_posted_cas_sched.sv
`timescale 1ns/1ps
module sim_posted_cas_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic [1:0]  cmd_bank = 2'd0;
   logic [12:0] cmd_addr = 13'd0;
   logic        iss_valid, iss_write, rd_window, wr_window;
   logic [1:0]  iss_bank;
   logic [12:0] iss_col;
   logic [2:0]  al_now, cl_now;
   logic        cfg_illegal, cfg_busy, rcd_early;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   posted_cas_sched u0 (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .iss_valid(iss_valid), .iss_write(iss_write),
      .iss_bank(iss_bank), .iss_col(iss_col), .rd_window(rd_window),
      .wr_window(wr_window), .al_now(al_now), .cl_now(cl_now),
      .cfg_illegal(cfg_illegal), .cfg_busy(cfg_busy), .rcd_early(rcd_early)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // drive one command for one edge; returns at the sample point after it
   task automatic send(input int op, input int bank, input int addr);
      cmd_op = 3'(op); cmd_bank = 2'(bank); cmd_addr = 13'(addr);
      @(negedge clk);
      cmd_op = 3'd0; cmd_bank = 2'd0; cmd_addr = 13'd0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input int al, input int cl);
      send(5, 0, al << 3);
      send(4, 0, cl << 4);
      idle(1);
   endtask

   task automatic t_reset;
      chk("R1 al_now", al_now, 0);
      chk("R1 cl_now", cl_now, 3);
      chk("R1 rd_window", rd_window, 0);
      chk("R1 wr_window", wr_window, 0);
      chk("R1 iss_valid", iss_valid, 0);
      chk("R1 flags", {cfg_illegal, cfg_busy, rcd_early}, 0);
   endtask

   task automatic t_program;
      send(5, 0, 2 << 3);
      chk("R2 al_now", al_now, 2);
      chk("R2 no illegal", cfg_illegal, 0);
      send(4, 0, 5 << 4);
      chk("R3 cl_now", cl_now, 5);
      send(5, 0, 4 << 3);
      chk("R2 al max", al_now, 4);
      idle(2);
   endtask

   task automatic t_illegal;
      set_cfg(1, 4);
      send(5, 0, 5 << 3);
      chk("R4 al flag", cfg_illegal, 1);
      chk("R4 al kept", al_now, 1);
      send(4, 0, 2 << 4);
      chk("R4 cl low flag", cfg_illegal, 1);
      chk("R4 cl kept", cl_now, 4);
      send(4, 0, 7 << 4);
      chk("R4 cl high flag", cfg_illegal, 1);
      chk("R4 cl kept hi", cl_now, 4);
      idle(1);
      chk("R4 flag clears", cfg_illegal, 0);
   endtask

   task automatic t_single(input bit wr, input int al, input int cl, input int bank, input int col);
      int lat;
      lat = wr ? al + cl - 1 : al + cl;
      set_cfg(al, cl);
      send(wr ? 3 : 2, bank, col);
      chk("R9 untouched bank", rcd_early, 0);
      for (int d = 0; d < 14; d++) begin
         chk("R5 iss_valid", iss_valid, (d == al) ? 1 : 0);
         if (d == al) begin
            chk("R5 iss_write", iss_write, wr);
            chk("R5 iss_bank", iss_bank, bank);
            chk("R5 iss_col", iss_col, col);
         end
         if (wr) begin
            chk("R7 wr_window", wr_window, (d >= lat && d < lat + 2) ? 1 : 0);
            chk("R7 no rd", rd_window, 0);
         end else begin
            chk("R6 rd_window", rd_window, (d >= lat && d < lat + 2) ? 1 : 0);
            chk("R6 no wr", wr_window, 0);
         end
         @(negedge clk);
      end
      idle(4);
   endtask

   task automatic t_back_to_back;
      set_cfg(1, 4);
      for (int t = 0; t < 16; t++) begin
         if (t == 0 || t == 2 || t == 4) begin
            cmd_op = 3'd2; cmd_bank = 2'd1; cmd_addr = 13'(10 + t / 2);
         end else begin
            cmd_op = 3'd0; cmd_addr = 13'd0;
         end
         @(negedge clk);
         chk("R8 iss_valid", iss_valid, (t == 1 || t == 3 || t == 5) ? 1 : 0);
         if (t == 1 || t == 3 || t == 5) chk("R8 order", iss_col, 10 + (t - 1) / 2);
         chk("R8 rd run", rd_window, (t >= 5 && t <= 10) ? 1 : 0);
      end
      cmd_op = 3'd0;
      idle(4);
   endtask

   task automatic t_busy;
      set_cfg(0, 3);
      send(2, 0, 5);
      send(5, 0, 3 << 3);
      chk("R10 busy flag", cfg_busy, 1);
      chk("R10 al kept", al_now, 0);
      @(negedge clk);
      chk("R10 rd d2", rd_window, 0);
      @(negedge clk);
      chk("R10 rd d3", rd_window, 1);
      @(negedge clk);
      chk("R10 rd d4", rd_window, 1);
      @(negedge clk);
      chk("R10 rd d5", rd_window, 0);
      send(5, 0, 3 << 3);
      chk("R10 idle accept", al_now, 3);
      chk("R10 no busy", cfg_busy, 0);
      idle(2);
   endtask

   task automatic t_rcd;
      set_cfg(2, 3);
      send(1, 1, 0);
      send(2, 1, 7);
      chk("R9 early gap1 al2", rcd_early, 1);
      idle(16);
      send(1, 2, 0);
      idle(1);
      send(3, 2, 8);
      chk("R9 ok gap2 al2", rcd_early, 0);
      idle(16);
      set_cfg(0, 3);
      send(1, 3, 0);
      idle(1);
      send(2, 3, 9);
      chk("R9 early gap2 al0", rcd_early, 1);
      idle(4);
      send(2, 3, 9);
      chk("R9 ok after settle", rcd_early, 0);
      idle(12);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_program;
      idle(2);
      t_illegal;
      idle(4);
      t_single(1'b0, 0, 3, 2, 33);
      t_single(1'b0, 2, 5, 1, 100);
      t_single(1'b0, 4, 6, 3, 4095);
      t_single(1'b1, 0, 3, 0, 17);
      t_single(1'b1, 3, 4, 2, 511);
      t_back_to_back;
      t_busy;
      t_rcd;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule